// File: doc/BRIEF.md
# Dual-Channel Serial Converter Code Register Front-End

This block is the digital input side of a two-channel, 12-bit serial-input converter. A host shifts a 14-bit frame into a serial register on rising edges of the serial clock while chip select is held low. The frame starts with a 2-bit channel address and ends with a 12-bit code, most significant bit first. The two held codes drive the converter switches of channel A and channel B. The ladder, the reference and the output amplifier are outside this block.

The two channel registers are level-sensitive latches. They are open while the active-low load strobe is low and closed while it is high. The address prefix of the frame in the serial register decodes to one of three targets: `TGT_BOTH`, `TGT_A` or `TGT_B`. The decode is combinational and has no sequence. The target changes as soon as the address bits in the serial register change, so the latch enables follow the current frame. An optional flag reports each bit shifted in while the strobe is low, because such a bit alters the outputs directly.

Top module: `dual_dac_front`

## Requirements
- R1: After reset, both output codes are 000h, the flag is low and the serial register holds zero. A load with no frame shifted therefore drives 000h onto both channels.
- R2: On each rising serial clock edge with `cs_n` low, the serial register shifts left by one and takes `sdi` into bit 0. After 14 such edges, bits [13:12] hold the address (first bit in bit 13) and bits [11:0] hold the code, MSB first.
- R3: On a rising serial clock edge with `cs_n` high, the serial register keeps its contents whatever `sdi` does.
- R4: Address bits [13:12] equal to 00 or 01 (first address bit 0) select both channels. Both codes take bits [11:0].
- R5: Address bits [13:12] equal to 10 select channel A only. `code_b` keeps its value.
- R6: Address bits [13:12] equal to 11 select channel B only. `code_a` keeps its value.
- R7: While `load_n` is high, both output codes hold, even when new frames are shifted in.
- R8: While `load_n` is low, each selected channel is transparent, whatever `cs_n` and the clock are doing. Every bit shifted in shows at the outputs after that edge, and the enables are re-decoded from the new address bits.
- R9: With `HAS_FLAG` = 1, `shift_open` is high for the clock period that follows a rising edge where both `cs_n` and `load_n` were low. It is low after any other edge.
- R10: Codes use straight binary and pass unaltered: 000h gives 000h (zero scale), 800h gives 800h (midscale) and FFFh gives FFFh (full scale).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; data is taken on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdi | input | 1 | Serial data in |
| cs_n | input | 1 | Active-low chip select; gates shifting |
| load_n | input | 1 | Active-low load strobe; opens the channel latches |
| code_a | output | 12 | Held code of channel A |
| code_b | output | 12 | Held code of channel B |
| shift_open | output | 1 | High after a bit was shifted while the latches were open |

## Verification
The bench covers these corner cases:
- **Transparent window.** A bit is shifted while `load_n` is held low, and the new bit changes the address from "both" to "A only". A latch built as an edge-triggered register would miss the change. A decode taken from a stale address would update B as well.
- **Address 01.** A decoder that compares the whole address would treat 01 as a channel and load nothing or one channel, where both channels must load.
- **Clocks with chip select high.** Clock edges arrive with `cs_n` high and random `sdi`. An ungated shift register would lose the frame before the load.
- **Flag timing.** The flag is checked after edges where the strobe was high. A flag that stays set, or that ignores chip select, would show there.

// File: rtl/dual_dac_pkg.sv
package dual_dac_pkg;

    // Channel target decoded from the address prefix of a frame
    typedef enum logic [1:0] {
        TGT_BOTH = 2'd0,
        TGT_A    = 2'd1,
        TGT_B    = 2'd2
    } dac_target_e;

endpackage

// File: rtl/dac_shift_reg.sv
module dac_shift_reg #(
    parameter int FRAME_W = 14
) (
    input  logic               sclk,
    input  logic               rst_n,
    input  logic               shift_en,
    input  logic               sdi,
    output logic [FRAME_W-1:0] frame_q
);

    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            frame_q <= '0;
        end else if (shift_en) begin
            frame_q <= {frame_q[FRAME_W-2:0], sdi};
        end
    end

endmodule

// File: rtl/dac_addr_decode.sv
module dac_addr_decode
    import dual_dac_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              open,
    output dac_target_e       target,
    output logic [1:0]        latch_en
);

    // First address bit low selects both; otherwise the second bit picks the channel
    always_comb begin
        unique case (addr[ADDR_W-1 -: 2])
            2'b00, 2'b01: target = TGT_BOTH;
            2'b10:        target = TGT_A;
            2'b11:        target = TGT_B;
            default:      target = TGT_BOTH;
        endcase
    end

    always_comb begin
        latch_en[0] = open && (target == TGT_BOTH || target == TGT_A);
        latch_en[1] = open && (target == TGT_BOTH || target == TGT_B);
    end

endmodule

// File: rtl/dac_code_latch.sv
module dac_code_latch #(
    parameter int DATA_W = 12
) (
    input  logic              rst_n,
    input  logic              en,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);

    // Intentional level-sensitive storage: open while en is high
    always_latch begin
        if (!rst_n) begin
            q <= '0;
        end else if (en) begin
            q <= d;
        end
    end

endmodule

// File: rtl/dual_dac_front.sv
module dual_dac_front
    import dual_dac_pkg::*;
#(
    parameter int DATA_W   = 12,
    parameter int ADDR_W   = 2,
    parameter bit HAS_FLAG = 1'b1
) (
    input  logic              sclk,
    input  logic              rst_n,
    input  logic              sdi,
    input  logic              cs_n,
    input  logic              load_n,
    output logic [DATA_W-1:0] code_a,
    output logic [DATA_W-1:0] code_b,
    output logic              shift_open
);

    localparam int FRAME_W = ADDR_W + DATA_W;
    localparam int NUM_CH  = 2;

    logic [FRAME_W-1:0] frame_q;
    logic [NUM_CH-1:0]  latch_en;
    logic [DATA_W-1:0]  ch_code [NUM_CH];
    dac_target_e        target;

    dac_shift_reg #(.FRAME_W(FRAME_W)) u_shift (
        .sclk     (sclk),
        .rst_n    (rst_n),
        .shift_en (!cs_n),
        .sdi      (sdi),
        .frame_q  (frame_q)
    );

    dac_addr_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr     (frame_q[FRAME_W-1:DATA_W]),
        .open     (!load_n),
        .target   (target),
        .latch_en (latch_en)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        dac_code_latch #(.DATA_W(DATA_W)) u_latch (
            .rst_n (rst_n),
            .en    (latch_en[ch]),
            .d     (frame_q[DATA_W-1:0]),
            .q     (ch_code[ch])
        );
    end

    assign code_a = ch_code[0];
    assign code_b = ch_code[1];

    if (HAS_FLAG) begin : g_flag
        logic flag_q;
        always_ff @(posedge sclk or negedge rst_n) begin
            if (!rst_n) begin
                flag_q <= 1'b0;
            end else begin
                flag_q <= !cs_n && !load_n;
            end
        end
        assign shift_open = flag_q;
    end else begin : g_noflag
        assign shift_open = 1'b0;
    end

endmodule

// File: rtl/dual_dac_front_chk.sv
module dual_dac_front_chk #(
    parameter int DATA_W   = 12,
    parameter int ADDR_W   = 2,
    parameter bit HAS_FLAG = 1'b1
) (
    input logic                     sclk,
    input logic                     rst_n,
    input logic                     sdi,
    input logic                     cs_n,
    input logic                     load_n,
    input logic [DATA_W-1:0]        code_a,
    input logic [DATA_W-1:0]        code_b,
    input logic                     shift_open,
    input logic [ADDR_W+DATA_W-1:0] frame_q
);

    localparam int TOP = ADDR_W + DATA_W - 1;

    assert_shift_R2: assert property (@(posedge sclk) disable iff (!rst_n)
        !cs_n |=> frame_q == {$past(frame_q[TOP-1:0]), $past(sdi)});

    assert_hold_frame_R3: assert property (@(posedge sclk) disable iff (!rst_n)
        cs_n |=> $stable(frame_q));

    assert_open_a_R8: assert property (@(posedge sclk) disable iff (!rst_n)
        (!load_n && !(frame_q[TOP] && frame_q[TOP-1])) |-> code_a == frame_q[DATA_W-1:0]);

    assert_open_b_R8: assert property (@(posedge sclk) disable iff (!rst_n)
        (!load_n && !(frame_q[TOP] && !frame_q[TOP-1])) |-> code_b == frame_q[DATA_W-1:0]);

    assert_closed_R7: assert property (@(posedge sclk) disable iff (!rst_n)
        (load_n && $past(load_n)) |-> ($stable(code_a) && $stable(code_b)));

    if (HAS_FLAG) begin : g_flag_chk
        assert_flag_set_R9: assert property (@(posedge sclk) disable iff (!rst_n)
            (!cs_n && !load_n) |=> shift_open);
        assert_flag_clr_R9: assert property (@(posedge sclk) disable iff (!rst_n)
            (cs_n || load_n) |=> !shift_open);
    end

endmodule

bind dual_dac_front dual_dac_front_chk #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .HAS_FLAG (HAS_FLAG)
) u_chk (
    .sclk       (sclk),
    .rst_n      (rst_n),
    .sdi        (sdi),
    .cs_n       (cs_n),
    .load_n     (load_n),
    .code_a     (code_a),
    .code_b     (code_b),
    .shift_open (shift_open),
    .frame_q    (frame_q)
);

// File: tb/dual_dac_front_tb.sv
module dual_dac_front_tb;

    logic        sclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sdi = 1'b0;
    logic        cs_n = 1'b1;
    logic        load_n = 1'b1;
    logic [11:0] code_a;
    logic [11:0] code_b;
    logic        shift_open;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 sclk = ~sclk;

    dual_dac_front u_dut (
        .sclk       (sclk),
        .rst_n      (rst_n),
        .sdi        (sdi),
        .cs_n       (cs_n),
        .load_n     (load_n),
        .code_a     (code_a),
        .code_b     (code_b),
        .shift_open (shift_open)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Shifts a 14-bit frame, first bit is bit 13; ends with cs_n high
    task automatic send_frame(input logic [13:0] f);
        for (int i = 13; i >= 0; i--) begin
            @(negedge sclk);
            cs_n = 1'b0;
            sdi = f[i];
        end
        @(negedge sclk);
        cs_n = 1'b1;
        #1;
    endtask

    task automatic pulse_load();
        @(negedge sclk);
        load_n = 1'b0;
        #2;
        @(negedge sclk);
        load_n = 1'b1;
        #1;
    endtask

    task automatic shift_one(input logic b);
        @(negedge sclk);
        cs_n = 1'b0;
        sdi = b;
        @(negedge sclk);
        cs_n = 1'b1;
        #1;
    endtask

    task automatic t_reset();
        check("R1 code_a after reset", code_a, 12'h000);
        check("R1 code_b after reset", code_b, 12'h000);
        check("R1 flag after reset", shift_open, 0);
        pulse_load();
        check("R1 empty register loads zero A", code_a, 12'h000);
        check("R1 empty register loads zero B", code_b, 12'h000);
    endtask

    task automatic t_both();
        send_frame({2'b00, 12'h800});
        check("R7 held before load A", code_a, 12'h000);
        check("R9 flag low with strobe high", shift_open, 0);
        pulse_load();
        check("R4 R10 midscale A", code_a, 12'h800);
        check("R4 R10 midscale B", code_b, 12'h800);
        send_frame({2'b01, 12'hFFF});
        pulse_load();
        check("R4 addr 01 full scale A", code_a, 12'hFFF);
        check("R4 R10 addr 01 full scale B", code_b, 12'hFFF);
    endtask

    task automatic t_single();
        send_frame({2'b10, 12'h123});
        pulse_load();
        check("R5 A loads", code_a, 12'h123);
        check("R5 B holds", code_b, 12'hFFF);
        send_frame({2'b11, 12'h000});
        pulse_load();
        check("R6 R10 B zero scale", code_b, 12'h000);
        check("R6 A holds", code_a, 12'h123);
    endtask

    task automatic t_cs_hold();
        send_frame({2'b00, 12'hABC});
        for (int i = 0; i < 5; i++) begin
            @(negedge sclk);
            sdi = i[0];
        end
        pulse_load();
        check("R3 frame kept A", code_a, 12'hABC);
        check("R2 R3 frame kept B", code_b, 12'hABC);
    endtask

    task automatic t_transparent();
        @(negedge sclk);
        load_n = 1'b0;
        #1;
        check("R8 open shows frame", code_a, 12'hABC);
        // 0x0ABC<<1|1 = 0x1579: address 01 (both), code 579
        shift_one(1'b1);
        check("R8 R2 bit passes A", code_a, 12'h579);
        check("R8 bit passes B", code_b, 12'h579);
        check("R9 flag after open shift", shift_open, 1);
        // 0x1579<<1 = 0x2AF2: address 10 (A only), code AF2
        shift_one(1'b0);
        check("R8 redecode A", code_a, 12'hAF2);
        check("R8 R5 redecode B holds", code_b, 12'h579);
        @(negedge sclk);
        #1;
        check("R9 flag clears with cs high", shift_open, 0);
        check("R8 cs high no change", code_a, 12'hAF2);
        load_n = 1'b1;
        send_frame({2'b00, 12'h456});
        check("R7 closed A holds", code_a, 12'hAF2);
        check("R7 closed B holds", code_b, 12'h579);
        check("R9 flag low after closed shifts", shift_open, 0);
        pulse_load();
        check("R4 final load", code_b, 12'h456);
    endtask

    initial begin
        repeat (3) @(negedge sclk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_both();
        t_single();
        t_cs_hold();
        t_transparent();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule